// File: doc/BRIEF.md
# Alternating-Role Phase Gate Driver

This block produces the eight gate signals of a four-phase asymmetric half-bridge converter that feeds a switched reluctance machine. Every phase leg has an upper and a lower transistor. An upstream commutation stage tells the block when each phase conducts. An upstream current comparator tells it, cycle by cycle, whether the phase current should rise. During a conduction window one transistor of the leg is the commutating switch and stays on. The other is the chopping switch and follows the chop request, so the winding alternates between +Vdc (both on) and zero volts (one on, freewheeling through a diode). Outside the window both switches are off, which applies -Vdc until the current has decayed through both diodes.

A global strategy input selects one of two modes. In fixed mode the upper switch of every leg always chops. In balanced mode each leg swaps the two duties at the end of every conduction window, which happens once per electrical cycle. The upper and lower devices then share the switching losses. The swap depends only on that phase's own window, so it behaves the same for either direction of rotation and for motoring or generating.

Each leg is a small state machine with three states. `LEG_IDLE` means the window is closed and both gates are off. `LEG_HI_CHOPS` means the upper switch chops and the lower one commutates. `LEG_LO_CHOPS` means the lower switch chops and the upper one commutates. The transitions are:
- **enter_hi**: `LEG_IDLE` to `LEG_HI_CHOPS`. Taken when the window opens in fixed mode, or in balanced mode with the phase's role flag clear.
- **enter_lo**: `LEG_IDLE` to `LEG_LO_CHOPS`. Taken when the window opens in balanced mode with the role flag set.
- **leave**: either active state to `LEG_IDLE`. Taken when the window closes. In balanced mode this also inverts the role flag.
- **hold**: an active state stays put while the window stays open.

Top module: `phase_role_gate_drv`

## Requirements
- R1: A synchronous active-low reset sets every gate output low and clears every role flag, so the first window after reset has the upper switch chopping.
- R2: If a phase's window enable is low at a clock edge, both gates of that phase are low after that edge.
- R3: While a phase's window is open, its commutating gate is high and its chopping gate equals that phase's chop request from the same edge. A chop request of 1 therefore drives both gates high, and a request of 0 leaves only the commutating gate high.
- R4: With `balance_en` = 0 (fixed mode), every window uses the upper gate as the chopping switch and the lower gate as the commutating switch, and the role flags stay cleared.
- R5: With `balance_en` = 1 (balanced mode), the chopping duty of a phase moves to the other transistor each time that phase's window closes, so consecutive windows alternate between the upper and the lower gate chopping.
- R6: The roles of a window are fixed at the edge where the window opens, including the mode in force at that edge. A mode change inside an open window does not change which gate chops until the next window.
- R7: Each phase keeps its own role flag and is unaffected by the order, overlap or direction of the other phases' windows.
- R8: In balanced mode, with the same chop pattern in every window, an even number of windows on a phase gives equal transition counts on its upper and lower gates.
- R9: In fixed mode, the lower gate of a phase makes exactly two transitions per window, whatever the chop pattern.
- R10: Every gate output is registered. A change on any input shows on the gates after the next rising clock edge and not before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| balance_en | input | 1 | 1 = balanced (alternating roles), 0 = fixed (upper chops) |
| win_en | input | NUM_PHASES | Conduction-window enable, one bit per phase |
| chop_req | input | NUM_PHASES | Chop request from the current comparator, one bit per phase |
| gate_hi | output | NUM_PHASES | Upper transistor gate, one bit per phase |
| gate_lo | output | NUM_PHASES | Lower transistor gate, one bit per phase |

## Verification
Each gate reflects the window, chop and mode inputs of the previous rising edge. This is the one register stage of R10. The role flag that a window closing inverts is used only when the next window opens. So a stimulus applied at a falling edge is due at the following falling edge. The bench drives inputs at falling edges and updates its behavioural model at the rising edge from the inputs seen there. It compares all gates at the next falling edge, on every cycle. A direct check also samples a quarter period after a drive to confirm that no gate moves before the edge. The transition-count checks of R8 and R9 run over whole windows, including the cycle after each window closes, when the gates fall.

// File: rtl/role_gate_pkg.sv
package role_gate_pkg;

    typedef enum logic [1:0] {
        LEG_IDLE     = 2'd0,
        LEG_HI_CHOPS = 2'd1,
        LEG_LO_CHOPS = 2'd2
    } leg_state_e;

endpackage

// File: rtl/leg_role_flag.sv
module leg_role_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic balance_en,
    input  logic win_end,
    output logic lo_chops
);

    // Flag set means the lower switch chops in the next window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_chops <= 1'b0;
        end else if (!balance_en) begin
            lo_chops <= 1'b0;
        end else if (win_end) begin
            lo_chops <= ~lo_chops;
        end
    end

endmodule

// File: rtl/leg_fsm.sv
module leg_fsm
    import role_gate_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic balance_en,
    input  logic win_en,
    input  logic chop_req,
    input  logic lo_chops,
    output logic win_end,
    output logic gate_hi,
    output logic gate_lo
);

    leg_state_e state_q, state_d;
    logic       hi_d, lo_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LEG_IDLE: begin
                if (win_en) begin
                    state_d = (balance_en && lo_chops) ? LEG_LO_CHOPS : LEG_HI_CHOPS;
                end
            end
            LEG_HI_CHOPS, LEG_LO_CHOPS: begin
                if (!win_en) begin
                    state_d = LEG_IDLE;
                end
            end
            default: state_d = LEG_IDLE;
        endcase
    end

    assign win_end = (state_q != LEG_IDLE) && !win_en;

    // Gate values that apply in the state being entered.
    always_comb begin
        hi_d = 1'b0;
        lo_d = 1'b0;
        unique case (state_d)
            LEG_HI_CHOPS: begin
                hi_d = chop_req;
                lo_d = 1'b1;
            end
            LEG_LO_CHOPS: begin
                hi_d = 1'b1;
                lo_d = chop_req;
            end
            default: begin
                hi_d = 1'b0;
                lo_d = 1'b0;
            end
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= LEG_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Output register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gate_hi <= 1'b0;
            gate_lo <= 1'b0;
        end else begin
            gate_hi <= hi_d;
            gate_lo <= lo_d;
        end
    end

endmodule

// File: rtl/phase_role_gate_drv.sv
module phase_role_gate_drv #(
    parameter int NUM_PHASES = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  balance_en,
    input  logic [NUM_PHASES-1:0] win_en,
    input  logic [NUM_PHASES-1:0] chop_req,
    output logic [NUM_PHASES-1:0] gate_hi,
    output logic [NUM_PHASES-1:0] gate_lo
);

    logic [NUM_PHASES-1:0] win_end;
    logic [NUM_PHASES-1:0] lo_chops;

    for (genvar p = 0; p < NUM_PHASES; p++) begin : g_leg
        leg_role_flag u_flag (
            .clk        (clk),
            .rst_n      (rst_n),
            .balance_en (balance_en),
            .win_end    (win_end[p]),
            .lo_chops   (lo_chops[p])
        );

        leg_fsm u_fsm (
            .clk        (clk),
            .rst_n      (rst_n),
            .balance_en (balance_en),
            .win_en     (win_en[p]),
            .chop_req   (chop_req[p]),
            .lo_chops   (lo_chops[p]),
            .win_end    (win_end[p]),
            .gate_hi    (gate_hi[p]),
            .gate_lo    (gate_lo[p])
        );
    end

endmodule

// File: rtl/phase_role_gate_chk.sv
module phase_role_gate_chk #(
    parameter int NUM_PHASES = 4
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  balance_en,
    input logic [NUM_PHASES-1:0] win_en,
    input logic [NUM_PHASES-1:0] chop_req,
    input logic [NUM_PHASES-1:0] gate_hi,
    input logic [NUM_PHASES-1:0] gate_lo
);

    for (genvar p = 0; p < NUM_PHASES; p++) begin : g_chk
        assert_off_outside_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
            !win_en[p] |=> (!gate_hi[p] && !gate_lo[p]));

        assert_chop_both_on_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (win_en[p] && chop_req[p]) |=> (gate_hi[p] && gate_lo[p]));

        assert_freewheel_one_on_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (win_en[p] && !chop_req[p]) |=> ($countones({gate_hi[p], gate_lo[p]}) == 1));

        assert_fixed_upper_chops_R4: assert property (@(posedge clk) disable iff (!rst_n)
            ($rose(win_en[p]) && !balance_en && !chop_req[p]) |=> (gate_lo[p] && !gate_hi[p]));

        assert_no_mid_window_swap_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (win_en[p] && $past(win_en[p]) && !chop_req[p] && !$past(chop_req[p]))
            |=> (gate_hi[p] == $past(gate_hi[p])));
    end

endmodule

bind phase_role_gate_drv phase_role_gate_chk #(.NUM_PHASES(NUM_PHASES)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .balance_en (balance_en),
    .win_en     (win_en),
    .chop_req   (chop_req),
    .gate_hi    (gate_hi),
    .gate_lo    (gate_lo)
);

// File: tb/phase_role_gate_drv_tb_top.sv
`timescale 1ns/1ps
module phase_role_gate_drv_tb_top;

    localparam int NP = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          balance_en = 1'b0;
    logic [NP-1:0] win_en = '0;
    logic [NP-1:0] chop_req = '0;
    logic [NP-1:0] gate_hi;
    logic [NP-1:0] gate_lo;

    int    checks = 0;
    int    errors = 0;
    bit    finished = 0;
    bit    cmp_en = 0;
    string cur_req = "R3";

    phase_role_gate_drv #(.NUM_PHASES(NP)) dut_i (
        .clk(clk), .rst_n(rst_n), .balance_en(balance_en),
        .win_en(win_en), .chop_req(chop_req),
        .gate_hi(gate_hi), .gate_lo(gate_lo)
    );

    always #2.5 clk = ~clk;

    // Behavioural reference model.
    int            m_role [NP];
    bit            m_act  [NP];
    bit            m_upch [NP];
    logic [NP-1:0] exp_hi = '0;
    logic [NP-1:0] exp_lo = '0;

    always @(posedge clk) begin
        for (int p = 0; p < NP; p++) begin
            if (!rst_n) begin
                m_role[p] = 0; m_act[p] = 0; m_upch[p] = 1;
                exp_hi[p] = 0; exp_lo[p] = 0;
            end else begin
                if (!balance_en) m_role[p] = 0;
                else if (m_act[p] && !win_en[p]) m_role[p] = 1 - m_role[p];
                if (win_en[p]) begin
                    if (!m_act[p]) begin
                        m_act[p]  = 1;
                        m_upch[p] = !balance_en || (m_role[p] == 0);
                    end
                    exp_hi[p] = m_upch[p] ? chop_req[p] : 1'b1;
                    exp_lo[p] = m_upch[p] ? 1'b1 : chop_req[p];
                end else begin
                    m_act[p] = 0;
                    exp_hi[p] = 0; exp_lo[p] = 0;
                end
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Compare on every cycle.
    always @(negedge clk) begin
        if (cmp_en && rst_n) begin
            check({gate_hi, gate_lo} === {exp_hi, exp_lo}, cur_req,
                  int'({gate_hi, gate_lo}), int'({exp_hi, exp_lo}));
        end
    end

    // Transition counters on phase 0.
    int   cnt_hi = 0, cnt_lo = 0;
    logic prv_hi = 0, prv_lo = 0;
    always @(negedge clk) begin
        if (gate_hi[0] !== prv_hi) cnt_hi++;
        if (gate_lo[0] !== prv_lo) cnt_lo++;
        prv_hi = gate_hi[0];
        prv_lo = gate_lo[0];
    end

    function automatic logic chop_pat(input int c);
        return (c < 3) || (c >= 5 && c < 7);
    endfunction

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic window(input int ph, input int len);
        for (int c = 0; c < len; c++) begin
            win_en[ph] = 1'b1;
            chop_req[ph] = chop_pat(c);
            tick(1);
        end
        win_en[ph] = 1'b0;
        chop_req[ph] = 1'b0;
        tick(3);
    endtask

    task automatic staggered(input bit reverse);
        for (int t = 0; t < 30; t++) begin
            for (int p = 0; p < NP; p++) begin
                int s;
                s = reverse ? (NP - 1 - p) * 4 : p * 4;
                win_en[p]   = (t >= s) && (t < s + 10);
                chop_req[p] = (t >= s) && chop_pat(t - s);
            end
            tick(1);
        end
        win_en = '0; chop_req = '0;
        tick(2);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        win_en = '0; chop_req = '0;
        tick(3);
        rst_n = 1'b1;
        tick(1);
    endtask

    initial begin
        tick(1);
        win_en = '1; chop_req = '1;
        tick(2);
        // R1: gates low while reset held, despite active inputs
        check(gate_hi == '0 && gate_lo == '0, "R1", int'({gate_hi, gate_lo}), 0);
        do_reset();
        cmp_en = 1;

        // R1: first window after reset, balanced: upper chops
        balance_en = 1'b1;
        win_en[3] = 1'b1; chop_req[3] = 1'b0;
        tick(2);
        check(gate_hi[3] == 0 && gate_lo[3] == 1, "R1", int'({gate_hi[3], gate_lo[3]}), 1);
        win_en[3] = 1'b0;
        tick(3);
        do_reset();

        // R4 / R9: fixed mode, lower gate transitions per window
        cur_req = "R4";
        balance_en = 1'b0;
        cnt_lo = 0; cnt_hi = 0;
        for (int w = 0; w < 3; w++) window(0, 10);
        check(cnt_lo == 6, "R9", cnt_lo, 6);
        win_en[0] = 1'b1; chop_req[0] = 1'b0;
        tick(2);
        check(gate_hi[0] == 0 && gate_lo[0] == 1, "R4", int'({gate_hi[0], gate_lo[0]}), 1);
        win_en[0] = 1'b0;
        tick(3);

        // R5 / R8: balanced mode, four windows on phase 0
        cur_req = "R5";
        balance_en = 1'b1;
        cnt_lo = 0; cnt_hi = 0;
        window(0, 10);
        win_en[0] = 1'b1; chop_req[0] = 1'b0;
        tick(2);
        // R5: second window, lower chops, upper commutates
        check(gate_hi[0] == 1 && gate_lo[0] == 0, "R5", int'({gate_hi[0], gate_lo[0]}), 2);
        win_en[0] = 1'b0;
        tick(3);
        do_reset();
        balance_en = 1'b1;
        cnt_lo = 0; cnt_hi = 0;
        for (int w = 0; w < 4; w++) window(0, 10);
        check(cnt_hi == cnt_lo, "R8", cnt_hi, cnt_lo);
        check(cnt_hi == 12, "R8", cnt_hi, 12);

        // R7: forward and reverse staggered overlapping windows
        cur_req = "R7";
        staggered(0);
        staggered(1);
        staggered(0);
        win_en[2] = 1'b1; chop_req[2] = 1'b0;
        tick(2);
        // phase 2 has had 3 windows since reset: lower chops
        check(gate_hi[2] == 1 && gate_lo[2] == 0, "R7", int'({gate_hi[2], gate_lo[2]}), 2);
        win_en[2] = 1'b0;
        tick(3);

        // R6: mode change inside a window keeps roles
        cur_req = "R6";
        do_reset();
        balance_en = 1'b1;
        window(1, 10);
        win_en[1] = 1'b1; chop_req[1] = 1'b0;
        tick(2);
        balance_en = 1'b0;
        tick(3);
        check(gate_hi[1] == 1 && gate_lo[1] == 0, "R6", int'({gate_hi[1], gate_lo[1]}), 2);
        win_en[1] = 1'b0;
        tick(3);
        win_en[1] = 1'b1;
        tick(2);
        check(gate_hi[1] == 0 && gate_lo[1] == 1, "R4", int'({gate_hi[1], gate_lo[1]}), 1);
        win_en[1] = 1'b0;
        tick(3);

        // R10 / R2: one register stage
        cur_req = "R10";
        win_en[2] = 1'b1; chop_req[2] = 1'b1;
        #1.25;
        check(gate_hi[2] == 0 && gate_lo[2] == 0, "R10", int'({gate_hi[2], gate_lo[2]}), 0);
        tick(1);
        check(gate_hi[2] == 1 && gate_lo[2] == 1, "R3", int'({gate_hi[2], gate_lo[2]}), 3);
        win_en[2] = 1'b0;
        #1.25;
        check(gate_hi[2] == 1 && gate_lo[2] == 1, "R10", int'({gate_hi[2], gate_lo[2]}), 3);
        tick(1);
        check(gate_hi[2] == 0 && gate_lo[2] == 0, "R2", int'({gate_hi[2], gate_lo[2]}), 0);
        tick(2);

        cmp_en = 0;
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #500000;
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule